// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes configuration words that arrive on a slow three-wire serial link (a serial clock, a data line and a load strobe) and places their contents into one of three holding registers of a frequency-synthesizer control path. The three registers are a feedback-divider pair (a 6-bit swallow value and a 6-bit main value), a 6-bit reference-divider value, and an 18-bit function word. All three wires are asynchronous to the system clock. Each wire is passed through a synchronizer, and the block then finds the rising edges of the serial clock and of the load strobe in the system-clock domain.

Each serial-clock rise shifts one bit into a 20-bit word, most significant bit first. When the load strobe rises, the two bits shifted in last act as an address. They choose which register takes the rest of the word. Registers that the address does not select keep their values. The holding registers drive the outputs directly.

Top module: `triWireLoader`

## Requirements
- R1: On each synchronized serial-clock rise the 20-bit word shifts toward its upper end and takes the synchronized data bit at bit 0, so the bit sent first ends at bit 19. Without a serial-clock rise the word is unchanged.
- R2: The four output registers change only in the system cycle after a synchronized load-strobe rise. Serial-clock activity with no load rise leaves every output unchanged.
- R3: At a load rise, if word bits [1:0] are 00, then bits [7:2] go to `swallowVal` and bits [13:8] go to `mainVal`. Bits [19:14] have no effect, and `refVal` and `funcWord` are kept.
- R4: At a load rise, if word bits [1:0] are 10, then bits [7:2] go to `refVal`. Bits [19:8] have no effect, and the other outputs are kept.
- R5: At a load rise, if word bit 0 is 1, then bits [19:2] go to `funcWord`, with word bit 2 at `funcWord[0]` and word bit 19 at `funcWord[17]`. Bit 1 has no effect, and the divider outputs are kept.
- R6: Reset clears all four output registers and the shift word to zero.
- R7: The block does not count bits between loads. A load rise that follows fewer than 20 new bits transfers whatever the word holds at that moment, including bits left over from earlier words.
- R8: If a serial-clock rise and a load rise are detected in the same system cycle, the load transfers the word as it was before that shift, and the new bit is still shifted in. A later load with no new bits transfers the shifted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, sampled at serial-clock rise |
| serLoad | input | 1 | Load strobe, rising edge transfers the word |
| swallowVal | output | 6 | Feedback-divider swallow value |
| mainVal | output | 6 | Feedback-divider main value |
| refVal | output | 6 | Reference-divider value |
| funcWord | output | 18 | Function word, funcWord[0] from word bit 2 |

## Verification
A shift and a transfer can happen in the same system cycle. The bench provokes this by raising the serial clock and the load strobe on the same system edge, so both pass through identical synchronizers and both edges are detected together. The scoreboard predicts the transfer from the word as it stood before the new bit. It then issues a plain load with no new bits and checks that this second transfer carries the shifted word, which this time selects the function register.

// File: rtl/wlPkg.sv
package wlPkg;
  parameter int WORD_W  = 20;
  parameter int ADDR_W  = 2;
  parameter int FIELD_W = 6;
  localparam int FUNC_W = WORD_W - ADDR_W;
  localparam int A_LSB  = ADDR_W;
  localparam int B_LSB  = ADDR_W + FIELD_W;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_REF  = 2'd1,
    SEL_FUNC = 2'd2
  } wlSel_e;

  typedef struct packed {
    logic shiftEn;
    logic loadDiv;
    logic loadRef;
    logic loadFunc;
  } wlStrobes_t;

  // Bit 0 set selects the function word whatever bit 1 holds.
  function automatic wlSel_e classify(input logic [ADDR_W-1:0] addr);
    if (addr[0])      return SEL_FUNC;
    else if (addr[1]) return SEL_REF;
    else              return SEL_DIV;
  endfunction
endpackage

// File: rtl/wlSync.sv
module wlSync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else if (s == 0) stageQ[s] <= rawIn;
        else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/wlControl.sv
module wlControl
  import wlPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkLvl,
  input  logic              loadLvl,
  input  logic [ADDR_W-1:0] addrBits,
  output wlStrobes_t        strobes
);
  logic clkPrev, loadPrev;
  logic clkRise, loadRise;
  wlSel_e sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      clkPrev  <= clkLvl;
      loadPrev <= loadLvl;
    end
  end

  assign clkRise  = clkLvl & ~clkPrev;
  assign loadRise = loadLvl & ~loadPrev;

  always_comb begin
    sel              = classify(addrBits);
    strobes          = '0;
    strobes.shiftEn  = clkRise;
    strobes.loadDiv  = loadRise && (sel == SEL_DIV);
    strobes.loadRef  = loadRise && (sel == SEL_REF);
    strobes.loadFunc = loadRise && (sel == SEL_FUNC);
  end
endmodule

// File: rtl/wlDatapath.sv
module wlDatapath
  import wlPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               dataLvl,
  input  wlStrobes_t         strobes,
  output logic [ADDR_W-1:0]  addrBits,
  output logic [WORD_W-1:0]  wordOut,
  output logic [FIELD_W-1:0] aOut,
  output logic [FIELD_W-1:0] bOut,
  output logic [FIELD_W-1:0] rOut,
  output logic [FUNC_W-1:0]  fOut
);
  logic [WORD_W-1:0] shiftWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftWord <= '0;
    else if (strobes.shiftEn) shiftWord <= {shiftWord[WORD_W-2:0], dataLvl};
  end

  // Latches take the word as registered, before any shift of the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aOut <= '0;
      bOut <= '0;
    end else if (strobes.loadDiv) begin
      aOut <= shiftWord[A_LSB +: FIELD_W];
      bOut <= shiftWord[B_LSB +: FIELD_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rOut <= '0;
    else if (strobes.loadRef) rOut <= shiftWord[A_LSB +: FIELD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fOut <= '0;
    else if (strobes.loadFunc) fOut <= shiftWord[WORD_W-1:ADDR_W];
  end

  assign addrBits = shiftWord[ADDR_W-1:0];
  assign wordOut  = shiftWord;
endmodule

// File: rtl/triWireLoader.sv
module triWireLoader
  import wlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               serData,
  input  logic               serLoad,
  output logic [FIELD_W-1:0] swallowVal,
  output logic [FIELD_W-1:0] mainVal,
  output logic [FIELD_W-1:0] refVal,
  output logic [FUNC_W-1:0]  funcWord
);
  logic [2:0]        syncLvl;
  logic [ADDR_W-1:0] addrBits;
  logic [WORD_W-1:0] shiftWord;
  wlStrobes_t        strobes;

  wlSync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({serLoad, serData, serClk}),
    .syncOut (syncLvl)
  );

  wlControl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .clkLvl   (syncLvl[0]),
    .loadLvl  (syncLvl[2]),
    .addrBits (addrBits),
    .strobes  (strobes)
  );

  wlDatapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .dataLvl  (syncLvl[1]),
    .strobes  (strobes),
    .addrBits (addrBits),
    .wordOut  (shiftWord),
    .aOut     (swallowVal),
    .bOut     (mainVal),
    .rOut     (refVal),
    .fOut     (funcWord)
  );
endmodule

// File: rtl/triWireLoaderChk.sv
module triWireLoaderChk
  import wlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               serClk,
  input logic               serData,
  input logic               serLoad,
  input logic [WORD_W-1:0]  shiftWord,
  input logic [FIELD_W-1:0] swallowVal,
  input logic [FIELD_W-1:0] mainVal,
  input logic [FIELD_W-1:0] refVal,
  input logic [FUNC_W-1:0]  funcWord
);
  // Independent edge finders over the raw pins.
  logic [SYNC_STAGES:0]   ckChain, ldChain;
  logic [SYNC_STAGES-1:0] dChain;
  logic ckRise, ldRise, dLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckChain <= '0;
      ldChain <= '0;
      dChain  <= '0;
    end else begin
      ckChain <= {ckChain[SYNC_STAGES-1:0], serClk};
      ldChain <= {ldChain[SYNC_STAGES-1:0], serLoad};
      dChain  <= {dChain[SYNC_STAGES-2:0], serData};
    end
  end

  assign ckRise = ckChain[SYNC_STAGES-1] & ~ckChain[SYNC_STAGES];
  assign ldRise = ldChain[SYNC_STAGES-1] & ~ldChain[SYNC_STAGES];
  assign dLvl   = dChain[SYNC_STAGES-1];

  // R1
  shift_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ckRise |=> shiftWord == {$past(shiftWord[WORD_W-2:0]), $past(dLvl)});

  // R1
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ckRise |=> $stable(shiftWord));

  // R2
  load_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldRise |=> $stable(swallowVal) && $stable(mainVal) && $stable(refVal) && $stable(funcWord));

  // R3
  div_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldRise && shiftWord[1:0] == 2'b00 |=>
      swallowVal == $past(shiftWord[A_LSB +: FIELD_W]) &&
      mainVal == $past(shiftWord[B_LSB +: FIELD_W]) &&
      $stable(refVal) && $stable(funcWord));

  // R4
  ref_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldRise && shiftWord[1:0] == 2'b10 |=>
      refVal == $past(shiftWord[A_LSB +: FIELD_W]) &&
      $stable(swallowVal) && $stable(mainVal) && $stable(funcWord));

  // R5
  func_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldRise && shiftWord[0] |=>
      funcWord == $past(shiftWord[WORD_W-1:ADDR_W]) &&
      $stable(swallowVal) && $stable(mainVal) && $stable(refVal));

  // R8
  coincide_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldRise && ckRise && shiftWord[1:0] == 2'b10 |=>
      refVal == $past(shiftWord[A_LSB +: FIELD_W]));
endmodule

bind triWireLoader triWireLoaderChk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (.*);

// File: tb/triWireLoader_tb_top.sv
module triWireLoader_tb_top;
  import wlPkg::*;

  typedef struct {
    logic [FIELD_W-1:0] a;
    logic [FIELD_W-1:0] b;
    logic [FIELD_W-1:0] r;
    logic [FUNC_W-1:0]  f;
    string              req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic [FIELD_W-1:0] swallowVal, mainVal, refVal;
  logic [FUNC_W-1:0]  funcWord;

  int checks = 0, fails = 0;
  int pushed = 0, popped = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  logic [WORD_W-1:0]  mdlWord = '0;
  logic [FIELD_W-1:0] mdlA = '0, mdlB = '0, mdlR = '0;
  logic [FUNC_W-1:0]  mdlF = '0;

  always #10 clk = ~clk;

  triWireLoader dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .swallowVal(swallowVal), .mainVal(mainVal), .refVal(refVal), .funcWord(funcWord)
  );

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Model decode from the requirements: R3, R4, R5.
  task automatic modelLoad(input logic [WORD_W-1:0] w);
    if (w[0]) mdlF = w[WORD_W-1:ADDR_W];
    else if (w[1]) mdlR = w[A_LSB +: FIELD_W];
    else begin
      mdlA = w[A_LSB +: FIELD_W];
      mdlB = w[B_LSB +: FIELD_W];
    end
  endtask

  task automatic pushExp(input string req);
    expItem_t it;
    it.a = mdlA; it.b = mdlB; it.r = mdlR; it.f = mdlF; it.req = req;
    expQ.push_back(it);
    pushed++;
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk) serData = b;
    repeat (4) @(negedge clk);
    serClk = 1'b1;
    mdlWord = {mdlWord[WORD_W-2:0], b};
    repeat (4) @(negedge clk);
    serClk = 1'b0;
  endtask

  task automatic sendBits(input logic [WORD_W-1:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic pulseLoad(input string req);
    @(negedge clk) serLoad = 1'b1;
    modelLoad(mdlWord);
    pushExp(req);
    repeat (4) @(negedge clk);
    serLoad = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  // R8: serial-clock rise and load rise on the same system edge.
  task automatic coincide(input logic b, input string req);
    @(negedge clk) serData = b;
    repeat (4) @(negedge clk);
    serClk = 1'b1;
    serLoad = 1'b1;
    modelLoad(mdlWord);
    pushExp(req);
    mdlWord = {mdlWord[WORD_W-2:0], b};
    repeat (4) @(negedge clk);
    serClk = 1'b0;
    serLoad = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  // Monitor: pops each expectation once the outputs have settled.
  initial begin
    forever begin
      expItem_t it;
      wait (pushed > popped);
      repeat (8) @(negedge clk);
      it = expQ.pop_front();
      popped++;
      cmp(it.req, "swallowVal", 32'(swallowVal), 32'(it.a));
      cmp(it.req, "mainVal",    32'(mainVal),    32'(it.b));
      cmp(it.req, "refVal",     32'(refVal),     32'(it.r));
      cmp(it.req, "funcWord",   32'(funcWord),   32'(it.f));
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R6: reset state
    cmp("R6", "swallowVal", 32'(swallowVal), 32'd0);
    cmp("R6", "mainVal",    32'(mainVal),    32'd0);
    cmp("R6", "refVal",     32'(refVal),     32'd0);
    cmp("R6", "funcWord",   32'(funcWord),   32'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1, R3: divider word, MSB first, junk in upper bits
    sendBits({6'h2D, 6'd40, 6'd5, 2'b00}, 20);
    pulseLoad("R3");
    // R3: other upper bits, same fields
    sendBits({6'h12, 6'd40, 6'd5, 2'b00}, 20);
    pulseLoad("R3");
    // R4: reference word with junk above the field
    sendBits({12'hABC, 6'd33, 2'b10}, 20);
    pulseLoad("R4");
    // R5: function word, bit 1 clear then set
    sendBits({18'h2AAAA, 2'b01}, 20);
    pulseLoad("R5");
    sendBits({18'h15555, 2'b11}, 20);
    pulseLoad("R5");
    // R1: single bit at the top ends in funcWord[17]
    sendBits({18'h20000, 2'b01}, 20);
    pulseLoad("R1");
    // R2: full word shifted without load leaves outputs alone
    sendBits({6'h3F, 6'd63, 6'd63, 2'b00}, 20);
    repeat (2) @(negedge clk);
    pushExp("R2");
    repeat (14) @(negedge clk);
    // R7: short word reuses older bits
    sendBits(20'b10100, 5);
    pulseLoad("R7");
    // R8: coincident shift and load, then a plain load of the shifted word
    sendBits({12'h000, 6'd9, 2'b10}, 20);
    coincide(1'b1, "R8");
    pulseLoad("R8");

    wait (popped == pushed);
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule